// File: doc/BRIEF.md
# EPROM Operating Mode Emulator

This block is a synthesizable behavioural stand-in for a word-wide, electrically erasable EPROM. It lets programmer logic be exercised on a clock-driven model of the memory. On every clock it decodes the control pins and a coded A9 level, VCC level and VPP level into one operating mode. The modes are read, output disable, standby, program, program verify, program inhibit, erase, erase verify, erase inhibit and identifier read. It keeps a small word array and drives a data bus with a separate drive-enable, so that the bus can be three-stated around it.

Cell physics is reduced to two rules. Programming can only clear bits. Only a whole-array erase can set bits again. Access and float delays are counted in clock cycles, and each delay is a parameter.

Level codes are the same for the VCC and VPP rails: `00` = normal supply, `01` = programming level, `10` = erase level, `11` = invalid. The A9 level codes are: `00` = logic level, `01` = identifier level, `10` = erase level, `11` = invalid. The "high level" of VPP means code `01` or `10`. Every mode below requires VCC at code `00`.

Top module: `eprom_mode_emu`

## Requirements
- R1: Program (VPP `01`, `ce_n`=0, `oe_n`=1, A9 `00`) replaces the addressed word with its old value bitwise ANDed with `din` on each clock. Bits can therefore only go from 1 to 0.
- R2: Erase (VPP `10`, A9 `10`, `ce_n`=0, `oe_n`=1, `addr`=0, `din` all ones) sets every word to all ones. If any one of these conditions is missing, the array is left unchanged.
- R3: Program verify (VPP `01`) and erase verify (VPP `10`) with `ce_n`=1 and `oe_n`=0 drive the addressed word. Drive starts at the T_OE-th clock after `oe_n` falls.
- R4: With VPP at `01` or `10` and both `ce_n` and `oe_n` high, the array is unchanged and the bus is not driven.
- R5: Standby (VPP `00`, `ce_n`=1) never drives the bus, whatever `oe_n` is.
- R6: Identifier read (VPP `00`, A9 `01`, `ce_n`=0, `oe_n`=0) returns 16'h00DA when `addr[0]`=0 and 16'h000D when `addr[0]`=1.
- R7: In read mode, data appears at the (T_ACC+1)-th clock after the last change of `addr` or `ce_n`. When the address has long been stable, data appears at the T_OE-th clock after `oe_n` falls.
- R8: When the drive condition ends, `dout_en` stays high for T_DF more clocks and then falls. During that time `dout` holds its last value.
- R9: Any pin combination that matches no mode, including VCC not at `00` or a rail at code `11`, leaves the array unchanged and the bus undriven.
- R10: After synchronous reset, every word reads all ones and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address; bit 0 plays the A0 role |
| a9_lvl | input | 2 | Coded A9 voltage level |
| vcc_lvl | input | 2 | Coded VCC rail level |
| vpp_lvl | input | 2 | Coded VPP rail level |
| din | input | DATA_W | Data bus input (program and erase data) |
| dout | output | DATA_W | Data bus output value |
| dout_en | output | 1 | Bus drive enable for the three-state buffer |

## Verification
The array is programmed with two overlapping words at the same address, so that the verify result separates an AND-merge from an overwrite. Erase is first attempted with A0 high and then with one data bit low, and only after that with the full condition. This shows that each erase condition gates the operation. Read latency is measured three ways: after a joint address/enable change, after an output-enable fall alone, and as the float delay after output enable rises. These three tell apart the access delay, the output-enable delay and the hold delay. Standby, inhibit and invalid rail codes are applied with destructive data on the bus, and the words they could have touched are read back afterwards.

// File: rtl/eprom_emu_pkg.sv
// Shared level codes, mode enumeration and identifier constants for the
// EPROM mode emulator. Assumes 2-bit level codes on every coded input.
package eprom_emu_pkg;

    localparam logic [1:0] LVL_NORM  = 2'b00;
    localparam logic [1:0] LVL_PROG  = 2'b01;
    localparam logic [1:0] LVL_ERASE = 2'b10;

    localparam logic [1:0] A9_LOGIC  = 2'b00;
    localparam logic [1:0] A9_IDENT  = 2'b01;
    localparam logic [1:0] A9_ERASE  = 2'b10;

    localparam logic [15:0] ID_MAKER  = 16'h00DA;
    localparam logic [15:0] ID_DEVICE = 16'h000D;

    typedef enum logic [3:0] {
        M_NONE,
        M_READ,
        M_OUT_DIS,
        M_STANDBY,
        M_PROG,
        M_PROG_VFY,
        M_PROG_INH,
        M_ERASE,
        M_ERASE_VFY,
        M_ERASE_INH,
        M_IDENT
    } op_mode_t;

endpackage

// File: rtl/eprom_mode_decode.sv
// Purely combinational mode decoder. Maps control pins and coded rail/A9
// levels onto one operating mode. Assumes VCC must sit at the normal code
// for any mode; everything unmatched decodes to M_NONE.
module eprom_mode_decode
    import eprom_emu_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        a9_lvl,
    input  logic [1:0]        vcc_lvl,
    input  logic [1:0]        vpp_lvl,
    input  logic [DATA_W-1:0] din,
    output op_mode_t          mode
);

    logic erase_pins_ok;

    // Erase qualifier: A9 at erase level, address all zero, data all ones.
    assign erase_pins_ok = (a9_lvl == A9_ERASE) && (addr == '0) && (&din);

    // Mode selection by rail level, then by enable pins.
    always_comb begin
        mode = M_NONE;
        if (vcc_lvl == LVL_NORM) begin
            case (vpp_lvl)
                LVL_NORM: begin
                    if (ce_n)
                        mode = M_STANDBY;
                    else if (a9_lvl == A9_LOGIC)
                        mode = oe_n ? M_OUT_DIS : M_READ;
                    else if ((a9_lvl == A9_IDENT) && !oe_n)
                        mode = M_IDENT;
                end
                LVL_PROG: begin
                    if (!ce_n && oe_n && (a9_lvl == A9_LOGIC))
                        mode = M_PROG;
                    else if (ce_n && !oe_n)
                        mode = M_PROG_VFY;
                    else if (ce_n && oe_n)
                        mode = M_PROG_INH;
                end
                LVL_ERASE: begin
                    if (!ce_n && oe_n && erase_pins_ok)
                        mode = M_ERASE;
                    else if (ce_n && !oe_n)
                        mode = M_ERASE_VFY;
                    else if (ce_n && oe_n)
                        mode = M_ERASE_INH;
                end
                default: mode = M_NONE;
            endcase
        end
    end

endmodule

// File: rtl/eprom_access_timer.sv
// Access delay counters. One counter measures clocks since address and chip
// enable became stable (chip enable low), the other measures clocks since
// output enable fell. Both saturate. Flags are based on the values the
// counters take at the coming edge, so a change seen at an edge restarts
// the count at once.
module eprom_access_timer #(
    parameter int ADDR_W = 6,
    parameter int T_ACC  = 4,
    parameter int T_OE   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_ok,
    output logic              oe_ok
);

    localparam int ACC_W = $clog2(T_ACC + 2);
    localparam int OE_W  = $clog2(T_OE + 2);

    logic [ACC_W-1:0]  acc_q, acc_nx;
    logic [OE_W-1:0]   oe_q, oe_nx;
    logic [ADDR_W-1:0] addr_q;
    logic              ce_n_q;
    logic              stable;

    assign stable = !ce_n && !ce_n_q && (addr == addr_q);

    // Next address-access count: restart on change, saturate at the limit.
    always_comb begin
        if (!stable)
            acc_nx = '0;
        else if (acc_q >= ACC_W'(T_ACC))
            acc_nx = acc_q;
        else
            acc_nx = acc_q + ACC_W'(1);
    end

    // Next output-enable count: zero while disabled, saturate at the limit.
    always_comb begin
        if (oe_n)
            oe_nx = '0;
        else if (oe_q >= OE_W'(T_OE))
            oe_nx = oe_q;
        else
            oe_nx = oe_q + OE_W'(1);
    end

    assign acc_ok = (acc_nx >= ACC_W'(T_ACC));
    assign oe_ok  = (oe_nx >= OE_W'(T_OE));

    // Register counts and the previous address / enable for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            oe_q   <= '0;
            addr_q <= '0;
            ce_n_q <= 1'b1;
        end else begin
            acc_q  <= acc_nx;
            oe_q   <= oe_nx;
            addr_q <= addr;
            ce_n_q <= ce_n;
        end
    end

endmodule

// File: rtl/eprom_cell_array.sv
// Word array with EPROM cell semantics: program ANDs data into one word,
// erase sets the whole array to ones. Reset leaves the array erased.
// Asynchronous read of the addressed word.
module eprom_cell_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Array update: bulk set on reset or erase, bit-clearing merge on program.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_en) begin
            for (int i = 0; i < DEPTH; i++)
                cells[i] <= '1;
        end else if (pgm_en) begin
            cells[addr] <= cells[addr] & din;
        end
    end

    assign rd_data = cells[addr];

endmodule

// File: rtl/eprom_out_stage.sv
// Registered output stage. Loads data and raises the enable while drive is
// requested. After the request ends, it keeps the last data on the bus for
// T_DF clocks before releasing. A T_DF of zero gives a stage with no hold
// counter.
module eprom_out_stage #(
    parameter int DATA_W = 16,
    parameter int T_DF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive,
    input  logic [DATA_W-1:0] drive_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    // Data register: follows the source while driving, frozen otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (drive)
            dout <= drive_data;
    end

    generate
        if (T_DF == 0) begin : g_no_hold
            // Enable follows the drive request directly.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dout_en <= 1'b0;
                else
                    dout_en <= drive;
            end
        end else begin : g_hold
            localparam int HOLD_W = $clog2(T_DF + 2);
            logic [HOLD_W-1:0] hold_q;

            // Enable with a release delay counted by hold_q.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dout_en <= 1'b0;
                    hold_q  <= '0;
                end else if (drive) begin
                    dout_en <= 1'b1;
                    hold_q  <= '0;
                end else if (dout_en) begin
                    if (hold_q >= HOLD_W'(T_DF))
                        dout_en <= 1'b0;
                    else
                        hold_q <= hold_q + HOLD_W'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/eprom_mode_emu.sv
// Top of the EPROM mode emulator. Joins the decoder, the access timer, the
// cell array and the output stage. Read and identifier modes need both
// access delays met; verify modes need only the output-enable delay.
// Assumes one clock domain and inputs synchronous to clk.
module eprom_mode_emu
    import eprom_emu_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int T_ACC  = 4,
    parameter int T_OE   = 2,
    parameter int T_DF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        a9_lvl,
    input  logic [1:0]        vcc_lvl,
    input  logic [1:0]        vpp_lvl,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    op_mode_t          mode;
    logic              acc_ok, oe_ok;
    logic              is_read, is_verify, drive;
    logic [DATA_W-1:0] rd_data, id_word, drive_data;

    eprom_mode_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .a9_lvl  (a9_lvl),
        .vcc_lvl (vcc_lvl),
        .vpp_lvl (vpp_lvl),
        .din     (din),
        .mode    (mode)
    );

    eprom_access_timer #(.ADDR_W(ADDR_W), .T_ACC(T_ACC), .T_OE(T_OE)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .addr   (addr),
        .acc_ok (acc_ok),
        .oe_ok  (oe_ok)
    );

    eprom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (mode == M_PROG),
        .erase_en (mode == M_ERASE),
        .addr     (addr),
        .din      (din),
        .rd_data  (rd_data)
    );

    // Drive request and source selection for the output stage.
    always_comb begin
        is_read    = (mode == M_READ) || (mode == M_IDENT);
        is_verify  = (mode == M_PROG_VFY) || (mode == M_ERASE_VFY);
        drive      = (is_read && acc_ok && oe_ok) || (is_verify && oe_ok);
        id_word    = addr[0] ? DATA_W'(ID_DEVICE) : DATA_W'(ID_MAKER);
        drive_data = (mode == M_IDENT) ? id_word : rd_data;
    end

    eprom_out_stage #(.DATA_W(DATA_W), .T_DF(T_DF)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .drive      (drive),
        .drive_data (drive_data),
        .dout       (dout),
        .dout_en    (dout_en)
    );

endmodule

// File: rtl/eprom_mode_emu_chk.sv
// Port-level property checker for eprom_mode_emu, attached by bind.
// Assumes the top's default level codes and identifier constants.
module eprom_mode_emu_chk
    import eprom_emu_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int T_DF   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        a9_lvl,
    input logic [1:0]        vcc_lvl,
    input logic [1:0]        vpp_lvl,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    localparam int QW = $clog2(T_DF + 3);

    logic          quiet;
    logic [QW-1:0] quiet_cnt;

    assign quiet = oe_n || (vcc_lvl != LVL_NORM);

    // Count consecutive clocks in which no mode may request drive.
    always_ff @(posedge clk) begin
        if (!rst_n)
            quiet_cnt <= '0;
        else if (!quiet)
            quiet_cnt <= '0;
        else if (quiet_cnt <= QW'(T_DF))
            quiet_cnt <= quiet_cnt + QW'(1);
    end

    p_float_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_cnt > QW'(T_DF)) |-> !dout_en);

    p_hold_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && $past(dout_en) && $past(oe_n)) |-> $stable(dout));

    p_rise_needs_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en) |-> !$past(oe_n));

    p_rise_after_stable_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dout_en) && !$past(ce_n)) |-> !$past(ce_n, 2));

    p_ident_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dout_en) && $past(vcc_lvl == LVL_NORM && vpp_lvl == LVL_NORM &&
                                 !ce_n && a9_lvl == A9_IDENT))
        |-> (dout == ($past(addr[0]) ? DATA_W'(ID_DEVICE) : DATA_W'(ID_MAKER))));

endmodule

bind eprom_mode_emu eprom_mode_emu_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .T_DF   (T_DF)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .addr    (addr),
    .a9_lvl  (a9_lvl),
    .vcc_lvl (vcc_lvl),
    .vpp_lvl (vpp_lvl),
    .dout    (dout),
    .dout_en (dout_en)
);

// File: tb/eprom_mode_emu_test.sv
// Bench: behavioural reference model compared every clock, plus directed
// value and latency checks.
module eprom_mode_emu_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int TACC = 4;
    localparam int TOE = 2;
    localparam int TDF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [1:0]    a9_lvl = 2'b00, vcc_lvl = 2'b00, vpp_lvl = 2'b00;
    logic [DW-1:0] din = '1;
    logic [DW-1:0] dout;
    logic          dout_en;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";
    bit    running = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eprom_mode_emu #(.ADDR_W(AW), .DATA_W(DW), .T_ACC(TACC), .T_OE(TOE), .T_DF(TDF)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .addr(addr),
        .a9_lvl(a9_lvl), .vcc_lvl(vcc_lvl), .vpp_lvl(vpp_lvl), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    // ---------------- reference model ----------------
    logic [DW-1:0] m_mem [0:(1<<AW)-1];
    logic [DW-1:0] m_dout = '0;
    logic          m_en = 1'b0;
    int            m_acc = 0, m_oe = 0, m_hold = 0;
    logic [AW-1:0] m_prev_addr = '0;
    logic          m_prev_ce = 1'b1;

    // Mode codes: 0 none,1 read,2 outdis,3 standby,4 prog,5 pvfy,6 pinh,7 erase,8 evfy,9 einh,10 ident
    function automatic int model_mode();
        if (vcc_lvl != 2'b00) return 0;
        if (vpp_lvl == 2'b00) begin
            if (ce_n) return 3;
            if (a9_lvl == 2'b00) return oe_n ? 2 : 1;
            if (a9_lvl == 2'b01 && !oe_n) return 10;
            return 0;
        end
        if (vpp_lvl == 2'b01) begin
            if (!ce_n && oe_n && a9_lvl == 2'b00) return 4;
            if (ce_n && !oe_n) return 5;
            if (ce_n && oe_n) return 6;
            return 0;
        end
        if (vpp_lvl == 2'b10) begin
            if (!ce_n && oe_n && a9_lvl == 2'b10 && addr == 0 && din == 16'hFFFF) return 7;
            if (ce_n && !oe_n) return 8;
            if (ce_n && oe_n) return 9;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
            m_en = 0; m_dout = 0; m_acc = 0; m_oe = 0; m_hold = 0;
            m_prev_ce = 1; m_prev_addr = 0;
        end else begin
            int  md;
            bit  drv;
            md = model_mode();
            if (!ce_n && !m_prev_ce && addr == m_prev_addr)
                m_acc = (m_acc < TACC) ? m_acc + 1 : m_acc;
            else
                m_acc = 0;
            m_oe = oe_n ? 0 : ((m_oe < TOE) ? m_oe + 1 : m_oe);
            drv = ((md == 1 || md == 10) && m_acc >= TACC && m_oe >= TOE) ||
                  ((md == 5 || md == 8) && m_oe >= TOE);
            if (drv) begin
                m_en = 1; m_hold = 0;
                m_dout = (md == 10) ? (addr[0] ? 16'h000D : 16'h00DA) : m_mem[addr];
            end else if (m_en) begin
                if (m_hold >= TDF) m_en = 0;
                else m_hold++;
            end
            if (md == 4) m_mem[addr] = m_mem[addr] & din;
            if (md == 7) foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
            m_prev_ce = ce_n;
            m_prev_addr = addr;
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (running) begin
            checks++;
            if (dout_en !== m_en || (m_en && dout !== m_dout)) begin
                errors++;
                $display("FAIL %s: model compare dout_en=%0d dout=%h, expected dout_en=%0d dout=%h",
                         cur_req, dout_en, dout, m_en, m_dout);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic pins(input logic c, input logic o, input logic [AW-1:0] a,
                        input logic [1:0] a9, input logic [1:0] vc, input logic [1:0] vp,
                        input logic [DW-1:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; addr = a; a9_lvl = a9; vcc_lvl = vc; vpp_lvl = vp; din = d;
    endtask

    task automatic idle();
        pins(1, 1, '0, 2'b00, 2'b00, 2'b00, '1);
        repeat (TDF + 3) @(posedge clk);
    endtask

    task automatic read_word(input string tag, input logic [1:0] a9,
                             input logic [AW-1:0] a, input logic [DW-1:0] exp);
        cur_req = tag;
        pins(0, 0, a, a9, 2'b00, 2'b00, '1);
        repeat (TACC + 1) @(posedge clk);
        @(negedge clk);
        check(tag, {15'd0, dout_en}, 16'd1);
        check(tag, dout, exp);
        idle();
    endtask

    task automatic verify_word(input string tag, input logic [1:0] vp,
                               input logic [AW-1:0] a, input logic [DW-1:0] exp);
        cur_req = tag;
        pins(1, 0, a, 2'b00, 2'b00, vp, '1);
        repeat (TOE) @(posedge clk);
        @(negedge clk);
        check(tag, {15'd0, dout_en}, 16'd1);
        check(tag, dout, exp);
        idle();
    endtask

    task automatic count_until(input logic want, output int n);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (dout_en === want) break;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        @(negedge clk);
        check("R10", {15'd0, dout_en}, 16'd0);
        read_word("R10", 2'b00, 6'd5, 16'hFFFF);

        // R7: joint address / enable change latency
        cur_req = "R7";
        pins(0, 0, 6'd3, 2'b00, 2'b00, 2'b00, '1);
        count_until(1'b1, n);
        check("R7", 16'(n), 16'(TACC + 1));
        // R7: output-enable-only latency
        @(negedge clk); oe_n = 1'b1;
        repeat (TDF + 3) @(posedge clk);
        @(negedge clk); oe_n = 1'b0;
        count_until(1'b1, n);
        check("R7", 16'(n), 16'(TOE));
        // R8: float delay after output enable rises
        cur_req = "R8";
        @(negedge clk); oe_n = 1'b1;
        count_until(1'b0, n);
        check("R8", 16'(n), 16'(TDF + 1));
        idle();

        // R1: two overlapping program words merge by AND
        cur_req = "R1";
        pins(0, 1, 6'd7, 2'b00, 2'b00, 2'b01, 16'hF0F3);
        pins(0, 1, 6'd7, 2'b00, 2'b00, 2'b01, 16'h3CFF);
        pins(1, 1, 6'd7, 2'b00, 2'b00, 2'b01, 16'h3CFF);
        @(posedge clk);
        verify_word("R1", 2'b01, 6'd7, 16'h30F3);
        verify_word("R3", 2'b01, 6'd9, 16'hFFFF);

        // R4: inhibit with destructive data
        cur_req = "R4";
        pins(1, 1, 6'd7, 2'b00, 2'b00, 2'b01, 16'h0000);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R4", {15'd0, dout_en}, 16'd0);
        pins(1, 1, 6'd7, 2'b10, 2'b00, 2'b10, 16'h0000);
        repeat (5) @(posedge clk);
        verify_word("R4", 2'b01, 6'd7, 16'h30F3);

        // R5: standby with output enable low
        cur_req = "R5";
        pins(1, 0, 6'd7, 2'b00, 2'b00, 2'b00, '1);
        repeat (TOE + TDF + 3) @(posedge clk);
        @(negedge clk);
        check("R5", {15'd0, dout_en}, 16'd0);
        idle();

        // R6: identifier codes
        read_word("R6", 2'b01, 6'd0, 16'h00DA);
        read_word("R6", 2'b01, 6'd1, 16'h000D);

        // R9: unmatched combinations
        cur_req = "R9";
        pins(0, 1, 6'd8, 2'b00, 2'b10, 2'b01, 16'h0000);
        repeat (3) @(posedge clk);
        pins(0, 0, 6'd8, 2'b00, 2'b00, 2'b01, 16'h0000);
        repeat (TACC + TDF + 3) @(posedge clk);
        @(negedge clk);
        check("R9", {15'd0, dout_en}, 16'd0);
        pins(1, 0, 6'd8, 2'b00, 2'b00, 2'b11, 16'h0000);
        repeat (TOE + TDF + 3) @(posedge clk);
        @(negedge clk);
        check("R9", {15'd0, dout_en}, 16'd0);
        idle();
        read_word("R9", 2'b00, 6'd8, 16'hFFFF);

        // R2: incomplete erase attempts, then a full erase
        cur_req = "R2";
        pins(0, 1, 6'd1, 2'b10, 2'b00, 2'b10, 16'hFFFF);
        repeat (3) @(posedge clk);
        pins(0, 1, 6'd0, 2'b10, 2'b00, 2'b10, 16'hFFFE);
        repeat (3) @(posedge clk);
        pins(1, 1, 6'd0, 2'b10, 2'b00, 2'b10, 16'hFFFF);
        @(posedge clk);
        verify_word("R2", 2'b10, 6'd7, 16'h30F3);
        pins(0, 1, 6'd0, 2'b10, 2'b00, 2'b10, 16'hFFFF);
        pins(1, 1, 6'd0, 2'b00, 2'b00, 2'b10, 16'hFFFF);
        @(posedge clk);
        verify_word("R2", 2'b10, 6'd7, 16'hFFFF);
        verify_word("R3", 2'b10, 6'd63, 16'hFFFF);

        running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule